// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

This block runs one write burst to a DDR2-style memory from the controller side. A client offers a write request. The request carries a bank, a starting column, a burst-length select of 4 or 8 beats and the whole burst of data. The sequencer drives the WRITE command on the command pins. It then waits out the write latency, which is additive latency plus CAS latency minus one. After that it runs the strobe through a one-clock low preamble and delivers the data to the PHY as one rising-edge beat and one falling-edge beat per clock.

After the last beat, the sequencer counts write recovery and then issues a single-bank PRECHARGE. It keeps its busy flag high until the row-precharge time has passed, so a low busy also means the bank may be activated again. The PHY is modelled at clock granularity. Each clock, the block drives a strobe-drive enable, a strobe-toggle flag, a data-drive enable and a beat pair. A toggling clock has the strobe rise at mid-data of the rising beat and fall for the falling beat. The strobe stays low through the second half of the final data clock, and that is the postamble.

All delays are whole clocks. The latency, recovery and precharge settings are sampled when the request is accepted.

Top module: `wr_burst_seq`

## Requirements
- R1: Cycle 0 is the clock after the edge that accepts a request. In cycle 0 the command pins {cs_n,ras_n,cas_n,we_n} are 0,1,0,0 (WRITE). cmd_bank equals the requested bank and cmd_addr is the column zero-extended, which leaves the auto-precharge bit (bit 10) at 0. In every cycle without a command the pins are all 1 and cmd_bank and cmd_addr are 0.
- R2: With WL = cfg_al + cfg_cl − 1 (never less than 2), the strobe preamble occupies cycle WL and the first data clock is cycle WL+1.
- R3: In the preamble cycle dqs_oe=1 and dqs_tgl=0. In every data clock dqs_oe=1 and dqs_tgl=1. In all other cycles both are 0, so the strobe is released right after the last data clock.
- R4: Beat i of the burst is req_data[i*DW +: DW]. Data clock j carries beat 2j on dq_rise and beat 2j+1 on dq_fall, with dq_oe=1.
- R5: req_bl8=1 gives 4 data clocks and req_bl8=0 gives 2 data clocks; with BL4 the upper four beats are ignored. Whenever dq_oe=0, dq_rise and dq_fall are 0, so no data leaks out after the burst.
- R6: The last data clock is L = WL + data clocks. PRECHARGE ({cs_n,ras_n,cas_n,we_n}=0,0,1,0, the written bank, cmd_addr=0) is issued in cycle L + tWR. A cfg_twr of 0 counts as 1.
- R7: Busy stays high through cycle P + tRP − 1, where P is the precharge cycle, and is low from cycle P + tRP. A cfg_trp of 0 counts as 1.
- R8: Busy is high from cycle 0 until the point in R7. Busy is 0 after reset. A request is accepted only at an edge where busy is low, and requests offered while busy are ignored and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_al | input | AL_W | Additive latency in clocks |
| cfg_cl | input | CL_W | CAS latency in clocks |
| cfg_twr | input | T_W | Write recovery in clocks |
| cfg_trp | input | T_W | Row precharge time in clocks |
| req_valid | input | 1 | Write request offered |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| req_data | input | 8*DW | Burst beats, beat 0 in the low bits |
| busy | output | 1 | Sequence in progress; low means the bank is ready again |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| dqs_oe | output | 1 | Strobe driven this clock |
| dqs_tgl | output | 1 | Strobe toggles this clock (0 while driven means held low) |
| dq_oe | output | 1 | Data driven this clock |
| dq_rise | output | DW | Beat for the rising strobe edge |
| dq_fall | output | DW | Beat for the falling strobe edge |

## Verification
The bench runs the shortest latency of 2, where the latency wait is a single clock. A counter that is off by one there would move the preamble onto the command clock or one clock late. It also runs the longest latency, with a full 8-beat burst, where a short counter would truncate the burst or a wrong shift would put beats on the wrong edge. Recovery and precharge of 1, including zero settings, check that precharge follows the last data clock directly and that busy falls one clock later. A design that loaded its counters with N instead of N−1 would stretch those gaps. Requests offered mid-burst with a different bank and column must leave both the command and data streams untouched and must not start a second burst.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WCMD,
        S_LAT,
        S_PREAMB,
        S_DATA,
        S_WREC,
        S_PRE,
        S_RP
    } seq_st_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_PRECH
    } cmd_kind_e;

endpackage

// File: rtl/wrseq_cmd_enc.sv
module wrseq_cmd_enc
    import wrseq_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 14
) (
    input  cmd_kind_e           kind,
    input  logic [BANK_W-1:0]   bank_i,
    input  logic [COL_W-1:0]    col_i,
    output logic                cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [BANK_W-1:0]   bank_o,
    output logic [ADDR_W-1:0]   addr_o
);

    always_comb begin
        cs_n   = 1'b1;
        ras_n  = 1'b1;
        cas_n  = 1'b1;
        we_n   = 1'b1;
        bank_o = '0;
        addr_o = '0;
        case (kind)
            CMD_WRITE: begin
                cs_n   = 1'b0;
                cas_n  = 1'b0;
                we_n   = 1'b0;
                bank_o = bank_i;
                addr_o = ADDR_W'(col_i);
            end
            CMD_PRECH: begin
                cs_n   = 1'b0;
                ras_n  = 1'b0;
                we_n   = 1'b0;
                bank_o = bank_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wrseq_beat_shift.sv
module wrseq_beat_shift #(
    parameter int DW    = 16,
    parameter int BEATS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [BEATS*DW-1:0] load_data,
    input  logic                advance,
    input  logic                out_en,
    output logic [DW-1:0]       rise,
    output logic [DW-1:0]       fall
);

    localparam int SRC_W  = BEATS * DW;
    localparam int PAIR_W = 2 * DW;

    logic [SRC_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = load_data;
        end else if (advance) begin
            data_d = data_q >> PAIR_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign rise = out_en ? data_q[DW-1:0]      : '0;
    assign fall = out_en ? data_q[PAIR_W-1:DW] : '0;

    // R4
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
    import wrseq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 14,
    parameter int AL_W   = 3,
    parameter int CL_W   = 3,
    parameter int T_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AL_W-1:0]      cfg_al,
    input  logic [CL_W-1:0]      cfg_cl,
    input  logic [T_W-1:0]       cfg_twr,
    input  logic [T_W-1:0]       cfg_trp,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_bl8,
    input  logic [8*DW-1:0]      req_data,
    output logic                 busy,
    output logic                 cmd_cs_n,
    output logic                 cmd_ras_n,
    output logic                 cmd_cas_n,
    output logic                 cmd_we_n,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic                 dqs_oe,
    output logic                 dqs_tgl,
    output logic                 dq_oe,
    output logic [DW-1:0]        dq_rise,
    output logic [DW-1:0]        dq_fall
);

    localparam int MAX_BEATS = 8;
    localparam int LAT_W     = ((AL_W > CL_W) ? AL_W : CL_W) + 1;
    localparam int CNT_W     = ((LAT_W > T_W) ? LAT_W : T_W) + 1;

    typedef struct packed {
        seq_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic                bl8;
        logic [T_W-1:0]      twr;
        logic [T_W-1:0]      trp;
        logic [BANK_W-1:0]   bank;
        logic [COL_W-1:0]    col;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             accept;
    logic [CNT_W-1:0] wl_raw;
    logic [CNT_W-1:0] wl_eff;
    cmd_kind_e        cmd_kind;

    always_comb begin
        c_d    = c_q;
        accept = req_valid && (c_q.st == S_IDLE);
        wl_raw = CNT_W'(cfg_al) + CNT_W'(cfg_cl);
        wl_eff = (wl_raw < CNT_W'(3)) ? CNT_W'(2) : (wl_raw - CNT_W'(1));
        case (c_q.st)
            S_IDLE: begin
                if (accept) begin
                    c_d.st   = S_WCMD;
                    c_d.bank = req_bank;
                    c_d.col  = req_col;
                    c_d.bl8  = req_bl8;
                    c_d.twr  = (cfg_twr == '0) ? T_W'(1) : cfg_twr;
                    c_d.trp  = (cfg_trp == '0) ? T_W'(1) : cfg_trp;
                    c_d.cnt  = wl_eff - CNT_W'(2);
                end
            end
            S_WCMD: c_d.st = S_LAT;
            S_LAT: begin
                if (c_q.cnt == '0) c_d.st = S_PREAMB;
                else               c_d.cnt = c_q.cnt - 1'b1;
            end
            S_PREAMB: begin
                c_d.st  = S_DATA;
                c_d.cnt = c_q.bl8 ? CNT_W'(3) : CNT_W'(1);
            end
            S_DATA: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (c_q.twr == T_W'(1)) begin
                    c_d.st = S_PRE;
                end else begin
                    c_d.st  = S_WREC;
                    c_d.cnt = CNT_W'(c_q.twr) - CNT_W'(2);
                end
            end
            S_WREC: begin
                if (c_q.cnt == '0) c_d.st = S_PRE;
                else               c_d.cnt = c_q.cnt - 1'b1;
            end
            S_PRE: begin
                if (c_q.trp == T_W'(1)) begin
                    c_d.st = S_IDLE;
                end else begin
                    c_d.st  = S_RP;
                    c_d.cnt = CNT_W'(c_q.trp) - CNT_W'(2);
                end
            end
            S_RP: begin
                if (c_q.cnt == '0) c_d.st = S_IDLE;
                else               c_d.cnt = c_q.cnt - 1'b1;
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy    = (c_q.st != S_IDLE);
    assign dqs_oe  = (c_q.st == S_PREAMB) || (c_q.st == S_DATA);
    assign dqs_tgl = (c_q.st == S_DATA);
    assign dq_oe   = (c_q.st == S_DATA);

    always_comb begin
        case (c_q.st)
            S_WCMD:  cmd_kind = CMD_WRITE;
            S_PRE:   cmd_kind = CMD_PRECH;
            default: cmd_kind = CMD_NONE;
        endcase
    end

    wrseq_cmd_enc #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) u_cmd (
        .kind   (cmd_kind),
        .bank_i (c_q.bank),
        .col_i  (c_q.col),
        .cs_n   (cmd_cs_n),
        .ras_n  (cmd_ras_n),
        .cas_n  (cmd_cas_n),
        .we_n   (cmd_we_n),
        .bank_o (cmd_bank),
        .addr_o (cmd_addr)
    );

    wrseq_beat_shift #(
        .DW    (DW),
        .BEATS (MAX_BEATS)
    ) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (req_data),
        .advance   (c_q.st == S_DATA),
        .out_en    (dq_oe),
        .rise      (dq_rise),
        .fall      (dq_fall)
    );

    logic is_wr_cmd, is_pre_cmd;
    assign is_wr_cmd  = !cmd_cs_n && cmd_ras_n && !cmd_cas_n && !cmd_we_n;
    assign is_pre_cmd = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n;

    // R3
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs_tgl)));

    // R8
    write_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr_cmd |-> ($past(req_valid) && !$past(busy)));

    // R5
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_rise == '0 && dq_fall == '0));

    // R6
    prech_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre_cmd |-> (!dq_oe && !dqs_oe && busy));

endmodule

// File: tb/wr_burst_seq_tb.sv
`timescale 1ns/1ps
module wr_burst_seq_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cfg_al = '0;
    logic [2:0]   cfg_cl = 3'd3;
    logic [3:0]   cfg_twr = 4'd1;
    logic [3:0]   cfg_trp = 4'd1;
    logic         req_valid = 1'b0;
    logic [2:0]   req_bank = '0;
    logic [9:0]   req_col = '0;
    logic         req_bl8 = 1'b0;
    logic [127:0] req_data = '0;
    logic         busy;
    logic         cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [2:0]   cmd_bank;
    logic [13:0]  cmd_addr;
    logic         dqs_oe, dqs_tgl, dq_oe;
    logic [15:0]  dq_rise, dq_fall;

    always #10 clk = ~clk;

    wr_burst_seq u_dut (.*);

    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  pins;
        logic [2:0]  bank;
        logic [13:0] addr;
        logic [2:0]  strb;
        logic [15:0] rise;
        logic [15:0] fall;
        logic        bsy;
    } exp_t;

    // kinds: 0 free, 1 latency wait, 2 write, 3 preamble, 4 data, 5 precharge, 6 recovery wait, 7 tRP wait
    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    function automatic exp_t mk(input logic [2:0] kind, input logic [3:0] pins,
                                input logic [2:0] bank, input logic [13:0] addr,
                                input logic [2:0] strb, input logic [15:0] r,
                                input logic [15:0] f, input logic b);
        exp_t e;
        e.kind = kind; e.pins = pins; e.bank = bank; e.addr = addr;
        e.strb = strb; e.rise = r; e.fall = f; e.bsy = b;
        return e;
    endfunction

    function automatic string cmd_tag(input logic [2:0] kind);
        case (kind)
            3'd2:    return "R1";
            3'd5:    return "R6";
            3'd6:    return "R6";
            3'd1:    return "R2";
            3'd3:    return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp_v);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (q.size() > 0) e = q.pop_front();
            else              e = mk(3'd0, 4'b1111, 3'd0, 14'd0, 3'b000, 16'd0, 16'd0, 1'b0);
            chk({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == e.pins && cmd_bank == e.bank && cmd_addr == e.addr,
                cmd_tag(e.kind), "cmd",
                {43'd0, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_bank, cmd_addr},
                {43'd0, e.pins, e.bank, e.addr});
            chk({dqs_oe, dqs_tgl, dq_oe} == e.strb, "R3", "strobe/enables",
                {61'd0, dqs_oe, dqs_tgl, dq_oe}, {61'd0, e.strb});
            chk(dq_rise == e.rise && dq_fall == e.fall, e.strb[0] ? "R4" : "R5", "beats",
                {32'd0, dq_rise, dq_fall}, {32'd0, e.rise, e.fall});
            chk(busy == e.bsy, (e.kind == 3'd7 || e.kind == 3'd0) ? "R7" : "R8", "busy",
                {63'd0, busy}, {63'd0, e.bsy});
        end
    end

    task automatic burst(input int al, input int cl, input int twr, input int trp,
                         input bit bl8, input logic [2:0] bk, input logic [9:0] col,
                         input logic [127:0] d, input bit refuse);
        int wl, nclk, twr_e, trp_e;
        wait (q.size() == 0);
        @(negedge clk);
        cfg_al = al[2:0]; cfg_cl = cl[2:0]; cfg_twr = twr[3:0]; cfg_trp = trp[3:0];
        req_valid = 1'b1; req_bank = bk; req_col = col; req_bl8 = bl8; req_data = d;
        @(posedge clk);
        #1;
        wl    = (al + cl - 1 < 2) ? 2 : al + cl - 1;
        nclk  = bl8 ? 4 : 2;
        twr_e = (twr == 0) ? 1 : twr;
        trp_e = (trp == 0) ? 1 : trp;
        // R1 write command in cycle 0
        q.push_back(mk(3'd2, 4'b0100, bk, {4'd0, col}, 3'b000, 16'd0, 16'd0, 1'b1));
        // R2 latency wait
        for (int k = 1; k < wl; k++)
            q.push_back(mk(3'd1, 4'b1111, 3'd0, 14'd0, 3'b000, 16'd0, 16'd0, 1'b1));
        // R3 preamble
        q.push_back(mk(3'd3, 4'b1111, 3'd0, 14'd0, 3'b100, 16'd0, 16'd0, 1'b1));
        // R4 data clocks, R5 count by burst length
        for (int j = 0; j < nclk; j++)
            q.push_back(mk(3'd4, 4'b1111, 3'd0, 14'd0, 3'b111,
                           d[(2*j)*16 +: 16], d[(2*j+1)*16 +: 16], 1'b1));
        // R6 recovery then precharge
        for (int k = 1; k < twr_e; k++)
            q.push_back(mk(3'd6, 4'b1111, 3'd0, 14'd0, 3'b000, 16'd0, 16'd0, 1'b1));
        q.push_back(mk(3'd5, 4'b0010, bk, 14'd0, 3'b000, 16'd0, 16'd0, 1'b1));
        // R7 precharge time
        for (int k = 1; k < trp_e; k++)
            q.push_back(mk(3'd7, 4'b1111, 3'd0, 14'd0, 3'b000, 16'd0, 16'd0, 1'b1));
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = '0;
        if (refuse) begin
            // R8 request while busy must be ignored
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_col = ~col; req_bank = ~bk; req_data = ~d;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    function automatic logic [127:0] pattern(input logic [7:0] tag);
        logic [127:0] v;
        for (int i = 0; i < 8; i++) v[i*16 +: 16] = {tag, 8'(i * 17 + 3)};
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(busy == 1'b0, "R8", "reset busy", {63'd0, busy}, 64'd0);
        chk(cmd_cs_n == 1'b1, "R1", "reset cs_n", {63'd0, cmd_cs_n}, 64'd1);
        chk(dqs_oe == 1'b0, "R3", "reset dqs_oe", {63'd0, dqs_oe}, 64'd0);
        chk(dq_oe == 1'b0 && dq_rise == '0, "R5", "reset data", {47'd0, dq_oe, dq_rise}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        burst(2, 3, 3, 2, 1'b0, 3'd1, 10'h05A, pattern(8'hA1), 1'b0); // WL 4, BL4
        burst(0, 3, 2, 1, 1'b0, 3'd2, 10'h100, pattern(8'hB2), 1'b0); // WL 2
        burst(0, 3, 1, 1, 1'b1, 3'd3, 10'h3F0, pattern(8'hC3), 1'b0); // tWR/tRP minimum, BL8
        burst(4, 6, 5, 4, 1'b1, 3'd4, 10'h011, pattern(8'hD4), 1'b1); // WL 9, refusal
        burst(1, 4, 0, 0, 1'b0, 3'd5, 10'h2AA, pattern(8'hE5), 1'b1); // zero settings count as 1
        burst(3, 5, 2, 3, 1'b1, 3'd7, 10'h3FF, pattern(8'h96), 1'b0); // max column

        wait (q.size() == 0);
        repeat (6) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule